// File: doc/BRIEF.md
# Clock Generator Power-Down Sequencer

This block manages the transition of a multi-output clock generator into and out of its low-power state. An asynchronous active-low sleep request is synchronised against the CPU clock and must be seen low on two consecutive CPU rising edges before it takes effect. Each single-ended output clock group is then frozen low on its own next falling edge, so no output is ever cut short in the middle of a high phase. The differential CPU pair is parked in one of two states, chosen by a configuration bit.

When the request is withdrawn, the block waits out a stabilization interval before any output runs again. The interval stands in for oscillator and PLL settling and is measured as a parameterised number of reference-clock rising edges. After that, each output restarts on its own next rising edge, and a ready flag rises once every output is running again. All clocks enter the block as sampled levels on one fast sampling clock. Each output is modelled as a level signal, plus a drive-enable where an output can float.

Top module: `clkpd_seq`

## Requirements
- R1: A sleep request is accepted only after its synchronised value (two flops advanced on CPU rising edges) is low on two consecutive CPU rising-edge samples. A low pulse that spans a single CPU rising edge is ignored: outputs keep running and ready stays 1.
- R2: Once the request is accepted, each single-ended output `grp_out[i]` goes low on the sample where its input `grp_clk_in[i]` falls, and then stays low. An output never falls while its input is high.
- R3: While parked with `park_mode` = 0, the CPU true output is driven high (`cpu_t_oe`=1, `cpu_t_lvl`=1) and the complement is undriven (`cpu_c_oe`=0).
- R4: While parked with `park_mode` = 1, both CPU outputs are undriven (`cpu_t_oe`=0, `cpu_c_oe`=0).
- R5: The slow reference group (index `REF_IDX`) parks on its own falling edge, which may come many CPU cycles after acceptance. Until then it keeps toggling in step with its input.
- R6: After the request returns high, every output stays low and `ready` stays 0 until `STAB_CYCLES` rising edges of the reference input have been counted.
- R7: When released, each output resumes on the sample where its input rises, so the first high phase is full length. An output never rises while its input is low.
- R8: `ready` is 1 in normal operation, drops to 0 once the request is accepted, and returns to 1 only when every output runs again.
- R9: After reset, all outputs follow their inputs one sampling cycle late: `cpu_t_lvl` equals the CPU clock, `cpu_c_lvl` is its inverse, both CPU enables are 1, and `ready` is 1.
- R10: A request that is accepted again during the stabilization wait returns the block to the parked state. A later release restarts the full count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock for all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_req_n | input | 1 | Asynchronous active-low sleep request |
| cpu_clk_in | input | 1 | Running CPU clock level |
| grp_clk_in | input | N_GRP | Running single-ended group clock levels |
| park_mode | input | 1 | CPU park style: 0 true high and driven, 1 both floating |
| grp_out | output | N_GRP | Gated single-ended output levels |
| cpu_t_lvl | output | 1 | CPU true output level |
| cpu_t_oe | output | 1 | CPU true drive enable |
| cpu_c_lvl | output | 1 | CPU complement output level |
| cpu_c_oe | output | 1 | CPU complement drive enable |
| ready | output | 1 | All outputs released and running |

## Verification
The group clocks run at four unrelated half-periods, the reference being the slowest. Every output is therefore caught at a different phase when the request arrives, and a monitor checks on every sample that each output edge falls on a matching input edge, which separates edge-aligned parking from an immediate cut. A one-edge request pulse is contrasted with a held request to tell the two-sample qualifier from a plain synchronizer. Release is tried once from a clean park and once with a re-request inside the wait, to show that the count truly restarts. The CPU park style is switched while parked to show both drive modes.

// File: rtl/clkpd_pkg.sv
package clkpd_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_PARK = 2'd1,
        ST_STAB = 2'd2
    } ctl_state_e;

    typedef struct packed {
        logic parked;
        logic lvl;
        logic prev;
    } gate_t;

endpackage

// File: rtl/clkpd_ctrl.sv
module clkpd_ctrl
    import clkpd_pkg::*;
#(
    parameter int STAB_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_req_n_i,
    input  logic cpu_clk_i,
    input  logic ref_clk_i,
    output logic park_req_o,
    output logic release_o
);
    localparam int CNT_W = (STAB_CYCLES > 1) ? $clog2(STAB_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STAB_CYCLES - 1);

    typedef struct packed {
        ctl_state_e       st;
        logic             s1;
        logic             s2;
        logic             low_seen;
        logic             cpu_prev;
        logic             ref_prev;
        logic [CNT_W-1:0] cnt;
    } ctl_t;

    ctl_t q, d;
    logic cpu_rise;
    logic ref_rise;
    logic qual_low;

    always_comb begin
        d        = q;
        cpu_rise = cpu_clk_i & ~q.cpu_prev;
        ref_rise = ref_clk_i & ~q.ref_prev;
        qual_low = cpu_rise & ~q.s2 & q.low_seen;
        d.cpu_prev = cpu_clk_i;
        d.ref_prev = ref_clk_i;
        if (cpu_rise) begin
            d.s1       = pd_req_n_i;
            d.s2       = q.s1;
            d.low_seen = ~q.s2;
        end
        case (q.st)
            ST_RUN: begin
                if (qual_low) d.st = ST_PARK;
            end
            ST_PARK: begin
                if (cpu_rise && q.s2) begin
                    d.st  = ST_STAB;
                    d.cnt = '0;
                end
            end
            ST_STAB: begin
                if (qual_low) begin
                    d.st = ST_PARK;
                end else if (ref_rise) begin
                    if (q.cnt == CNT_LAST) d.st = ST_RUN;
                    else                   d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_RUN, s1: 1'b1, s2: 1'b1, low_seen: 1'b0,
                   cpu_prev: 1'b0, ref_prev: 1'b0, cnt: '0};
        end else begin
            q <= d;
        end
    end

    assign park_req_o = (q.st != ST_RUN);
    assign release_o  = (q.st == ST_RUN);

    // R1: leaving normal operation needs an earlier low sample
    p_two_samples_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RUN && !q.low_seen) |=> (q.st == ST_RUN));

    // R6: no release before the final reference edge is counted
    p_stab_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_STAB && q.cnt != CNT_LAST) |=> (q.st != ST_RUN));

    // R10: renewed request during the wait parks again
    p_requal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_STAB && cpu_rise && !q.s2 && q.low_seen) |=> (q.st == ST_PARK));

endmodule

// File: rtl/clkpd_gate.sv
module clkpd_gate
    import clkpd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clk_i,
    input  logic park_req_i,
    input  logic release_i,
    output logic lvl_o,
    output logic parked_o
);
    gate_t q, d;
    logic  fall;
    logic  rise;

    always_comb begin
        d      = q;
        fall   = q.prev & ~clk_i;
        rise   = ~q.prev & clk_i;
        d.prev = clk_i;
        if (!q.parked && park_req_i && fall)
            d.parked = 1'b1;
        else if (q.parked && release_i && rise)
            d.parked = 1'b0;
        d.lvl = d.parked ? 1'b0 : clk_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign lvl_o    = q.lvl;
    assign parked_o = q.parked;

    // R2: an output parks only on a falling edge of its input
    p_park_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.parked && !(q.prev && !clk_i)) |=> !q.parked);

    // R7: an output leaves the parked state only on a rising edge
    p_resume_on_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.parked && !(!q.prev && clk_i)) |=> q.parked);

    // R7: the first value after unparking is high
    p_first_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.parked) |-> q.lvl);

endmodule

// File: rtl/clkpd_seq.sv
module clkpd_seq
    import clkpd_pkg::*;
#(
    parameter int N_GRP       = 4,
    parameter int REF_IDX     = 3,
    parameter int STAB_CYCLES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pd_req_n,
    input  logic             cpu_clk_in,
    input  logic [N_GRP-1:0] grp_clk_in,
    input  logic             park_mode,
    output logic [N_GRP-1:0] grp_out,
    output logic             cpu_t_lvl,
    output logic             cpu_t_oe,
    output logic             cpu_c_lvl,
    output logic             cpu_c_oe,
    output logic             ready
);
    logic             park_req;
    logic             release_ok;
    logic [N_GRP-1:0] grp_parked;
    logic             cpu_lvl;
    logic             cpu_parked;

    clkpd_ctrl #(.STAB_CYCLES(STAB_CYCLES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .pd_req_n_i (pd_req_n),
        .cpu_clk_i  (cpu_clk_in),
        .ref_clk_i  (grp_clk_in[REF_IDX]),
        .park_req_o (park_req),
        .release_o  (release_ok)
    );

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        clkpd_gate u_gate (
            .clk        (clk),
            .rst_n      (rst_n),
            .clk_i      (grp_clk_in[g]),
            .park_req_i (park_req),
            .release_i  (release_ok),
            .lvl_o      (grp_out[g]),
            .parked_o   (grp_parked[g])
        );
    end

    clkpd_gate u_cpu_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_i      (cpu_clk_in),
        .park_req_i (park_req),
        .release_i  (release_ok),
        .lvl_o      (cpu_lvl),
        .parked_o   (cpu_parked)
    );

    always_comb begin
        if (cpu_parked) begin
            cpu_t_lvl = ~park_mode;
            cpu_t_oe  = ~park_mode;
            cpu_c_lvl = 1'b0;
            cpu_c_oe  = 1'b0;
        end else begin
            cpu_t_lvl = cpu_lvl;
            cpu_t_oe  = 1'b1;
            cpu_c_lvl = ~cpu_lvl;
            cpu_c_oe  = 1'b1;
        end
    end

    assign ready = release_ok & ~cpu_parked & ~(|grp_parked);

    // R3: park style 0 drives true high, complement floats
    p_cpu_mode0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_parked && !park_mode) |-> (cpu_t_oe && cpu_t_lvl && !cpu_c_oe));

    // R4: park style 1 floats both legs
    p_cpu_mode1_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_parked && park_mode) |-> (!cpu_t_oe && !cpu_c_oe));

    // R8: ready never coexists with a pending sleep request
    p_ready_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !park_req);

    // R2: a parked group output is low
    p_parked_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (park_req && !release_ok && $past(park_req)) |-> ((grp_out & grp_parked) == '0));

endmodule

// File: tb/clkpd_seq_test.sv
module clkpd_seq_test;
    localparam int PERIOD  = 10;
    localparam int NG      = 4;
    localparam int REFI    = 3;
    localparam int STAB    = 8;
    localparam int REF_PER = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pd_req_n = 1'b1;
    logic          cpu_clk_in = 1'b0;
    logic [NG-1:0] grp_clk_in = '0;
    logic          park_mode = 1'b0;
    logic [NG-1:0] grp_out;
    logic          cpu_t_lvl, cpu_t_oe, cpu_c_lvl, cpu_c_oe, ready;

    int errors = 0;
    int checks = 0;
    int edge_bad = 0;
    bit mon_en = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    clkpd_seq #(.N_GRP(NG), .REF_IDX(REFI), .STAB_CYCLES(STAB)) uut (
        .clk(clk), .rst_n(rst_n), .pd_req_n(pd_req_n), .cpu_clk_in(cpu_clk_in),
        .grp_clk_in(grp_clk_in), .park_mode(park_mode), .grp_out(grp_out),
        .cpu_t_lvl(cpu_t_lvl), .cpu_t_oe(cpu_t_oe), .cpu_c_lvl(cpu_c_lvl),
        .cpu_c_oe(cpu_c_oe), .ready(ready)
    );

    // stimulus clocks, changed away from the sampling edge
    int hp [NG] = '{3, 5, 4, 9};
    int gcnt [NG] = '{0, 0, 0, 0};
    int ccnt = 0;
    always @(negedge clk) begin
        if (ccnt == 1) begin ccnt <= 0; cpu_clk_in <= ~cpu_clk_in; end
        else ccnt <= ccnt + 1;
        for (int i = 0; i < NG; i++) begin
            if (gcnt[i] == hp[i] - 1) begin
                gcnt[i] <= 0;
                grp_clk_in[i] <= ~grp_clk_in[i];
            end else gcnt[i] <= gcnt[i] + 1;
        end
    end

    // edge monitor: output edges must coincide with matching input edges (R2, R5, R7)
    logic [NG-1:0] p_out = '0, p_in = '0;
    always @(posedge clk) begin
        #1;
        if (mon_en) begin
            for (int i = 0; i < NG; i++) begin
                if (p_out[i] && !grp_out[i] && !(p_in[i] && !grp_clk_in[i])) edge_bad++;
                if (!p_out[i] && grp_out[i] && !(!p_in[i] && grp_clk_in[i])) edge_bad++;
            end
        end
        p_out = grp_out;
        p_in  = grp_clk_in;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic check_follow(input string tag);
        int bad = 0;
        for (int k = 0; k < 40; k++) begin
            step();
            if (grp_out != grp_clk_in || cpu_t_lvl != cpu_clk_in ||
                cpu_c_lvl != ~cpu_clk_in || !cpu_t_oe || !cpu_c_oe || !ready) bad++;
        end
        chk(bad == 0, tag, bad, 0);
    endtask

    task automatic check_parked(input string tag);
        int bad = 0;
        for (int k = 0; k < 40; k++) begin
            step();
            if (grp_out != '0 || ready) bad++;
        end
        chk(bad == 0, tag, bad, 0);
    endtask

    task automatic t_reset();
        step();
        chk(ready == 1'b1, "R9 ready after reset", ready, 1);
        chk(cpu_t_oe && cpu_c_oe, "R9 cpu enables after reset", {cpu_t_oe, cpu_c_oe}, 3);
        check_follow("R9 outputs follow inputs");
    endtask

    task automatic t_glitch();
        @(posedge cpu_clk_in);
        pd_req_n = 1'b0;
        @(negedge clk); @(negedge clk);
        pd_req_n = 1'b1;
        check_follow("R1 one-sample pulse ignored");
        check_follow("R1 still running later");
    endtask

    task automatic t_enter();
        int e0 = edge_bad;
        @(negedge clk);
        pd_req_n = 1'b0;
        repeat (60) step();
        check_parked("R2 all groups held low");
        chk(grp_out[REFI] == 1'b0, "R5 reference group parked", grp_out[REFI], 0);
        chk(ready == 1'b0, "R8 ready low while parked", ready, 0);
        chk(cpu_t_oe && cpu_t_lvl && !cpu_c_oe, "R3 cpu park style 0",
            {cpu_t_oe, cpu_t_lvl, cpu_c_oe}, 6);
        @(negedge clk); park_mode = 1'b1;
        step();
        chk(!cpu_t_oe && !cpu_c_oe, "R4 cpu park style 1", {cpu_t_oe, cpu_c_oe}, 0);
        @(negedge clk); park_mode = 1'b0;
        step();
        chk(edge_bad == e0, "R2 R5 parking on own falling edge", edge_bad - e0, 0);
    endtask

    task automatic t_release(input string tag);
        int bad = 0;
        int waited = 0;
        int e0 = edge_bad;
        @(negedge clk);
        pd_req_n = 1'b1;
        for (int k = 0; k < (STAB - 1) * REF_PER; k++) begin
            step(); waited++;
            if (grp_out != '0 || ready) bad++;
        end
        chk(bad == 0, {tag, " R6 held during stabilization"}, bad, 0);
        while (!ready && waited < 400) begin step(); waited++; end
        chk(ready && waited <= STAB * REF_PER + 60, {tag, " R8 ready returns"}, waited,
            STAB * REF_PER);
        chk(edge_bad == e0, {tag, " R7 resume on rising edge"}, edge_bad - e0, 0);
        check_follow({tag, " R7 running after release"});
    endtask

    task automatic t_requal();
        int bad = 0;
        @(negedge clk);
        pd_req_n = 1'b0;
        repeat (60) step();
        @(negedge clk);
        pd_req_n = 1'b1;
        repeat (60) step();
        @(negedge clk);
        pd_req_n = 1'b0;
        repeat (40) step();
        check_parked("R10 re-request parks again");
        t_release("R10");
    endtask

    initial begin
        #(PERIOD * 200000);
        errors++; checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) step();
        mon_en = 1'b1;
        t_reset();
        t_glitch();
        t_enter();
        t_release("R6");
        t_requal();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule